// File: doc/BRIEF.md
# Dual-Bank Interrupt Event Controller

This block gathers 64 interrupt request lines into two banks of 32 sources and drives a single interrupt request towards the processor. Each source has three state bits: a sticky event bit, a mask bit that software writes, and a level bit that follows the input line. Some sources are fixed as level-sensitive. These never latch an event, and they request service only while their line is high. All other sources are edge-latched. Their event bit holds a request until software clears it.

Software reaches the banks through a small synchronous register port. Each bank has a window of sixteen bytes. In it, software can read the event bits, read and write the mask, clear events by writing ones, and read the live levels. Data crosses the port in reversed byte order, in both directions. The processor interrupt output is registered. It asserts whenever any unmasked source in either bank has a pending event or, for a level-sensitive source, an active level.

Top module: `dbic_top`

## Requirements
- R1: After a clock edge with `rst_n` low, every event, mask and level register of both banks reads zero and `irq_o` is low.
- R2: Input line `src_i[n]` feeds bank `1 - n[5]` at bit `n[4:0]`. Lines 32..63 therefore land in bank 0 and lines 0..31 land in bank 1.
- R3: For edge-latched sources, the level bit equals the line value sampled at the last clock edge. The event bit is set at any edge where the line is high. A falling line clears only the level bit, and the event bit stays set until software clears it.
- R4: The bank 1 bits 20 through 28 (attribute value 0x1FF00000) are level-sensitive. Bank 0 has none. A level-sensitive source never sets its event bit and is not affected by a clear write.
- R5: `irq_o` is high exactly when, in either bank, `(event | (level & level_sensitive)) & mask` is nonzero. It updates at the same clock edge as the register state it reflects.
- R6: A write to bank offset 0x8 clears each event bit whose position is set in the written value.
- R7: If a line is high in the same cycle that a clear write targets its event bit, the event bit stays set.
- R8: Register data is byte-reversed on the port in both directions. Logical byte 0 (bits 7:0) travels on data bits 31:24, and so on, so logical value 0x12345678 appears on the bus as 0x78563412.
- R9: The bank index is `(addr[11:0] - 0x10) >> 4`. Only indices 0 and 1 are valid, which means addresses 0x10..0x1F for bank 0 and 0x20..0x2F for bank 1. Any other address reads zero and ignores writes.
- R10: Within a bank, offset 0x0 reads events, 0x4 reads and writes the mask, and 0xC reads levels. Offset 0x8 and every other offset read zero. Writes to any offset other than 0x4 and 0x8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Interrupt request lines, sampled each edge |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data, byte-reversed |
| bus_rdata | output | 32 | Read data for `bus_addr`, byte-reversed, combinational |
| irq_o | output | 1 | Registered processor interrupt request |

## Verification
A wrong event, mask or level bit appears at the ports in two ways. A read of the matching offset on the following cycle shows it. So does `irq_o`, as a spurious or missing request from the edge where the state changed. A wrong bank decode or swap appears as the state showing up in the other bank's window or in the wrong byte lane. Holding a line high across a clear, raising level-sensitive lines, and writing to invalid or read-only addresses each produce a visible difference within one cycle.

// File: rtl/dbic_pkg.sv
// Shared constants and helpers for the dual-bank interrupt event controller.
// Assumes 32-bit registers and byte-granular reversal on the register port.
package dbic_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned BANKS      = 2;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned WIN_BASE   = 'h10;

    // Fixed level-sensitive attribute of each bank.
    function automatic logic [REG_W-1:0] level_attr(input int unsigned bank);
        return (bank == 1) ? 32'h1FF0_0000 : 32'h0000_0000;
    endfunction

    // Reverse the byte order of a register word.
    function automatic logic [REG_W-1:0] byte_rev(input logic [REG_W-1:0] w);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_W / 8; i++) begin
            r[i*8 +: 8] = w[(REG_W/8 - 1 - i)*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/dbic_bank.sv
// One bank of sources: sticky events, mask and sampled levels.
// Assumes the write data is already in logical byte order and that
// the write enables are single-cycle and mutually exclusive.
module dbic_bank
    import dbic_pkg::*;
#(
    parameter int unsigned         W       = REG_W,
    parameter logic [REG_W-1:0]    LS_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic         mask_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] level_o,
    output logic         req_now_o,
    output logic         req_next_o
);
    localparam logic [W-1:0] LS = LS_BITS[W-1:0];

    logic [W-1:0] event_q, mask_q, level_q;
    logic [W-1:0] event_d, mask_d, clr_bits;

    // Clear vector: level-sensitive positions are never cleared.
    assign clr_bits = clr_we_i ? (wdata_i & ~LS) : '0;

    // Next state: a high edge-latched line wins over a same-cycle clear.
    always_comb begin
        event_d = (event_q & ~clr_bits) | (line_i & ~LS);
        mask_d  = mask_we_i ? wdata_i : mask_q;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= '0;
            mask_q  <= '0;
            level_q <= '0;
        end else begin
            event_q <= event_d;
            mask_q  <= mask_d;
            level_q <= line_i;
        end
    end

    assign event_o    = event_q;
    assign mask_o     = mask_q;
    assign level_o    = level_q;
    assign req_now_o  = |((event_q | (level_q & LS)) & mask_q);
    assign req_next_o = |((event_d | (line_i & LS)) & mask_d);

    // R3
    event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(event_q) & ~event_q & ~$past(clr_bits)) == '0));
    // R7
    line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(line_i) & ~LS & ~event_q) == '0));
    // R4
    ls_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((event_q & LS) == '0));
    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/dbic_regdec.sv
// Register port decode: bank/offset selection, write strobes and read mux.
// Assumes a 12-bit byte address, 16-byte windows starting at WIN_BASE.
module dbic_regdec
    import dbic_pkg::*;
#(
    parameter int unsigned W  = REG_W,
    parameter int unsigned NB = BANKS,
    parameter int unsigned AW = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr_i,
    input  logic                 wr_i,
    input  logic [W-1:0]         wdata_raw_i,
    input  logic [NB-1:0][W-1:0] event_i,
    input  logic [NB-1:0][W-1:0] mask_i,
    input  logic [NB-1:0][W-1:0] level_i,
    output logic [NB-1:0]        mask_we_o,
    output logic [NB-1:0]        clr_we_o,
    output logic [W-1:0]         wdata_o,
    output logic [W-1:0]         rdata_raw_o
);
    localparam int unsigned IDX_W = AW - 4;
    localparam int unsigned SEL_W = (NB > 1) ? $clog2(NB) : 1;

    logic [AW-1:0]    rel;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic [3:0]       off;
    logic             sel_valid;
    logic [W-1:0]     rd_logical;

    // Window index and offset from the address.
    always_comb begin
        rel       = addr_i - AW'(WIN_BASE);
        idx       = rel[AW-1:4];
        sel       = idx[SEL_W-1:0];
        off       = addr_i[3:0];
        sel_valid = (idx < IDX_W'(NB));
    end

    assign wdata_o = byte_rev(wdata_raw_i);

    // Per-bank write strobes.
    generate
        for (genvar b = 0; b < NB; b++) begin : g_we
            assign mask_we_o[b] = wr_i && sel_valid && (sel == SEL_W'(b)) && (off == 4'h4);
            assign clr_we_o[b]  = wr_i && sel_valid && (sel == SEL_W'(b)) && (off == 4'h8);
        end
    endgenerate

    // Read multiplexer over the selected bank.
    always_comb begin
        rd_logical = '0;
        if (sel_valid) begin
            case (off)
                4'h0:    rd_logical = event_i[sel];
                4'h4:    rd_logical = mask_i[sel];
                4'hC:    rd_logical = level_i[sel];
                default: rd_logical = '0;
            endcase
        end
    end

    assign rdata_raw_o = byte_rev(rd_logical);

    // R9
    bad_window_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (mask_we_o == '0 && clr_we_o == '0));
    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_we_o, clr_we_o}));
endmodule

// File: rtl/dbic_top.sv
// Dual-bank interrupt event controller top: maps lines to banks, instances
// the banks and the register decode, and registers the processor request.
// Assumes line n belongs to bank (NB-1 - n/W).
module dbic_top
    import dbic_pkg::*;
#(
    parameter int unsigned W  = REG_W,
    parameter int unsigned NB = BANKS,
    parameter int unsigned AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB*W-1:0] src_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic            irq_o
);
    logic [NB-1:0][W-1:0] ev, mk, lv;
    logic [NB-1:0]        mask_we, clr_we, req_now, req_next;
    logic [W-1:0]         wdata;
    logic                 irq_q;

    dbic_regdec #(.W(W), .NB(NB), .AW(AW)) regdec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .wdata_raw_i (bus_wdata),
        .event_i     (ev),
        .mask_i      (mk),
        .level_i     (lv),
        .mask_we_o   (mask_we),
        .clr_we_o    (clr_we),
        .wdata_o     (wdata),
        .rdata_raw_o (bus_rdata)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            dbic_bank #(.W(W), .LS_BITS(level_attr(b))) bank_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .line_i     (src_i[(NB-1-b)*W +: W]),
                .mask_we_i  (mask_we[b]),
                .clr_we_i   (clr_we[b]),
                .wdata_i    (wdata),
                .event_o    (ev[b]),
                .mask_o     (mk[b]),
                .level_o    (lv[b]),
                .req_now_o  (req_now[b]),
                .req_next_o (req_next[b])
            );
        end
    endgenerate

    // Registered processor request, aligned with the bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |req_next;
    end

    assign irq_o = irq_q;

    // R5
    irq_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |req_now));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && ev == '0 && mk == '0 && lv == '0));
endmodule

// File: tb/dbic_top_tb_top.sv
// Scoreboard bench: driver tasks push expected results, a monitor compares.
`timescale 1ns/1ps
module dbic_top_tb_top;
    localparam logic [31:0] LS1 = 32'h1FF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #2 clk = ~clk;

    dbic_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    tb_chk = 1'b0;
    bit    done = 1'b0;

    logic [31:0] m_ev [2];
    logic [31:0] m_mk [2];
    logic [31:0] m_lv [2];

    function automatic logic [31:0] swp(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] ls_of(input int b);
        return (b == 1) ? LS1 : 32'h0;
    endfunction

    function automatic logic [31:0] line_of(input int b);
        return (b == 0) ? src_i[63:32] : src_i[31:0];
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int b = 0; b < 2; b++)
            if (((m_ev[b] | (m_lv[b] & ls_of(b))) & m_mk[b]) != 0) r = 1;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int b;
        if (a < 12'h10 || a > 12'h2F) return 32'h0;
        b = (a < 12'h20) ? 0 : 1;
        case (a[3:0])
            4'h0:    return m_ev[b];
            4'h4:    return m_mk[b];
            4'hC:    return m_lv[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_i = v;
        for (int b = 0; b < 2; b++) begin
            m_lv[b] = line_of(b);
            m_ev[b] = m_ev[b] | (line_of(b) & ~ls_of(b));
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        int b;
        @(negedge clk);
        bus_addr = a; bus_wdata = swp(d); bus_wr = 1'b1;
        if (a >= 12'h10 && a <= 12'h2F) begin
            b = (a < 12'h20) ? 0 : 1;
            if (a[3:0] == 4'h4) m_mk[b] = d;
            if (a[3:0] == 4'h8)
                m_ev[b] = (m_ev[b] & ~(d & ~ls_of(b))) | (line_of(b) & ~ls_of(b));
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_read(input logic [11:0] a, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 0; it.exp = swp(m_read(a)); it.tag = tag;
        q.push_back(it);
        tb_chk = 1'b1;
        #1.5 tb_chk = 1'b0;
    endtask

    task automatic chk_read_val(input logic [11:0] a, input logic [31:0] raw, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 0; it.exp = raw; it.tag = tag;
        q.push_back(it);
        tb_chk = 1'b1;
        #1.5 tb_chk = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.exp = {31'b0, m_irq()}; it.tag = tag;
        q.push_back(it);
        tb_chk = 1'b1;
        #1.5 tb_chk = 1'b0;
    endtask

    // Monitor: compare one expected item per check strobe.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (tb_chk && q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) begin m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_read_val(12'h10, 32'h0, "R1 event0");
        chk_read_val(12'h14, 32'h0, "R1 mask0");
        chk_read_val(12'h2C, 32'h0, "R1 level1");
        chk_irq("R1 irq");

        // R2 mapping, R3 latching: line 40 -> bank 0 bit 8
        set_src(64'h1 << 40);
        chk_read_val(12'h10, swp(32'h100), "R2 event0 bit8");
        chk_read_val(12'h1C, swp(32'h100), "R3 level0 bit8");
        chk_read_val(12'h20, 32'h0, "R2 bank1 untouched");
        chk_irq("R5 masked off");

        // R8 swap on write and read
        bus_write(12'h24, 32'h1234_5678);
        chk_read_val(12'h24, 32'h7856_3412, "R8 swapped readback");
        bus_write(12'h24, 32'h0);
        bus_write(12'h14, 32'h0000_0100);
        chk_irq("R5 unmasked event");

        // R3 event persists after line falls
        set_src(64'h0);
        chk_read(12'h1C, "R3 level cleared");
        chk_read_val(12'h10, swp(32'h100), "R3 event sticky");
        chk_irq("R3 irq held");

        // R6 clear
        bus_write(12'h18, 32'h0000_0100);
        chk_read_val(12'h10, 32'h0, "R6 cleared");
        chk_irq("R6 irq drop");

        // R4 level-sensitive line 20 -> bank 1 bit 20
        set_src(64'h1 << 20);
        chk_read_val(12'h20, 32'h0, "R4 no event");
        chk_read_val(12'h2C, swp(32'h0010_0000), "R4 level");
        bus_write(12'h24, 32'h0010_0000);
        chk_irq("R4 level irq");
        set_src(64'h0);
        chk_irq("R4 level irq drop");

        // R7 line high during clear: line 5 -> bank 1 bit 5
        set_src(64'h1 << 5);
        bus_write(12'h28, 32'h0000_0020);
        chk_read_val(12'h20, swp(32'h20), "R7 assertion wins");
        set_src(64'h0);
        bus_write(12'h28, 32'h0000_0020);
        chk_read(12'h20, "R6 clear after release");

        // R9 invalid windows
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h034, 32'hFFFF_FFFF);
        chk_read_val(12'h14, swp(32'h100), "R9 mask0 unchanged");
        chk_read_val(12'h24, swp(32'h0010_0000), "R9 mask1 unchanged");
        chk_read_val(12'h004, 32'h0, "R9 low addr reads 0");
        chk_read_val(12'h034, 32'h0, "R9 high addr reads 0");

        // R10 offsets
        bus_write(12'h10, 32'hFFFF_FFFF);
        bus_write(12'h2C, 32'hFFFF_FFFF);
        chk_read_val(12'h10, 32'h0, "R10 event not writable");
        chk_read_val(12'h2C, 32'h0, "R10 level not writable");
        chk_read_val(12'h18, 32'h0, "R10 clear reads 0");
        chk_read_val(12'h15, 32'h0, "R10 odd offset reads 0");

        // R5 OR across banks
        bus_write(12'h14, 32'h8000_0000);
        bus_write(12'h24, 32'h0000_0020);
        set_src((64'h1 << 63) | (64'h1 << 5));
        set_src(64'h0);
        chk_irq("R5 both pending");
        bus_write(12'h18, 32'h8000_0000);
        chk_irq("R5 bank1 alone");
        bus_write(12'h28, 32'h0000_0020);
        chk_irq("R5 none pending");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule